// File: doc/BRIEF.md
# Clock-Stopping Call Bridge

This block connects a hardware design running on a gated, controlled clock to a software side that talks through two message ports, one outgoing and one incoming. Each port uses a valid/ready handshake. The block works in three kinds of call:

- **Imported call.** The hardware calls out to software and waits for the answer.
- **Exported function.** Software calls into hardware and the call takes no controlled time.
- **Exported task.** Software calls into hardware and the call may take many controlled-clock cycles.

Controlled design time is frozen by dropping a registered clock-enable output, `cclk_en`. This output is driven from a free-running clock and changes only on that clock's rising edge, so it cannot glitch. When it is low, the surrounding design's gated clock stands still.

Messages have fixed fields. A call identifier sits in bits `[ID_W-1:0]`. Field `k` (arguments or results, in declaration order) sits at bits `[ID_W + k*FLD_W +: FLD_W]`.

An incoming message is read in one of two ways:
- While the block waits for an imported-call reply, the message is that reply.
- Otherwise, the message is a new exported call. Its kind comes from the top bit of the identifier: 0 means a function, 1 means a task.

Only one call is in progress at a time.

Top module: `fcall_bridge`

## Requirements
- R1: After a synchronous reset the block is idle, with these outputs:
  - `cclk_en`=1, `out_valid`=0, `imp_req_ready`=1, `imp_done`=0 and `exp_go`=0.
  - `in_ready`=1 while `imp_req_valid` is low.
- R2: An imported call is accepted at the edge where `imp_req_valid` and `imp_req_ready` are both high. From that edge:
  - `cclk_en` is 0.
  - `out_valid` is 1, with `out_msg` holding `imp_id` in bits `[ID_W-1:0]` and argument `k` at `[ID_W+k*FLD_W +: FLD_W]`.
- R3: During an imported call, `cclk_en` stays 0 through the outgoing transfer and the wait for the reply. `in_ready` is 0 until the outgoing transfer has completed, and 1 while the reply is awaited.
- R4: At the edge where the reply transfers:
  - `imp_res` takes field `k` from bits `[ID_W+k*FLD_W +: FLD_W]` of `in_msg`; the reply's identifier field is not used.
  - `imp_done` pulses for one cycle.
  - `cclk_en` returns to 1 after that same edge, with the results already in place.
- R5: An incoming message accepted while idle, with identifier top bit 0, starts an exported function. From that edge:
  - `cclk_en` is 0.
  - `exp_go` pulses for one cycle.
  - `exp_id` and `exp_args` hold the identifier and fields until the next exported call.
- R6: An exported function ends at the edge where `exp_fin` is high; results are taken from `exp_res` at that edge. From that edge:
  - `out_msg` carries the call's identifier and the results, in the same layout as R2.
  - `cclk_en` stays 0 until the edge where `out_valid` and `out_ready` are both high, and is 1 afterwards.
- R7: An exported task (identifier top bit 1) leaves `cclk_en` at 1 when it is accepted and while it runs. `cclk_en` is 0 only from the `exp_fin` edge until the result message transfers, and is 1 again after that.
- R8: A message moves only in a cycle where valid and ready are both high. While `out_ready` is low, `out_valid` stays high and `out_msg` stays unchanged.
- R9: Only one call is outstanding at a time.
  - `imp_req_ready` is 0 whenever a call is in progress.
  - When `imp_req_valid` and `in_valid` are both high while idle, the imported call wins and `in_ready` is 0.
- R10: `exp_fin` is ignored unless an exported call is running. It produces no message and leaves `cclk_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running uncontrolled clock |
| rst | input | 1 | Synchronous reset, active high |
| cclk_en | output | 1 | Registered enable for the controlled clock |
| imp_req_valid | input | 1 | Hardware raises an imported call |
| imp_req_ready | output | 1 | Bridge can accept an imported call |
| imp_id | input | ID_W | Identifier of the imported call |
| imp_args | input | NFLD*FLD_W | Input arguments, field k at k*FLD_W |
| imp_done | output | 1 | One-cycle pulse: reply results are on imp_res |
| imp_res | output | NFLD*FLD_W | Return value and output arguments of the last reply |
| exp_go | output | 1 | One-cycle pulse: an exported call starts |
| exp_id | output | ID_W | Identifier of the running exported call |
| exp_args | output | NFLD*FLD_W | Arguments of the running exported call |
| exp_fin | input | 1 | Hardware signals that the exported call has finished |
| exp_res | input | NFLD*FLD_W | Results of the exported call, sampled with exp_fin |
| out_valid | output | 1 | Outgoing message valid |
| out_ready | input | 1 | Software accepts the outgoing message |
| out_msg | output | ID_W+NFLD*FLD_W | Outgoing message |
| in_valid | input | 1 | Incoming message valid |
| in_ready | output | 1 | Bridge accepts the incoming message |
| in_msg | input | ID_W+NFLD*FLD_W | Incoming message |

## Verification
The bench builds the bridge with `ID_W`=4, `FLD_W`=8 and `NFLD`=3, which gives 28-bit messages. With these values:
- Random identifiers land in both the function half and the task half of the identifier space.
- Field values of all zeros and all ones are cheap to hit directly, so field boundaries and the placement of every field can be seen in the packed words.
- Handshake stalls of zero to four cycles on each port exercise both the immediate-transfer case and the held-message case of every call kind.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_IMP_SEND = 3'd1,
    ST_IMP_WAIT = 3'd2,
    ST_FN_RUN   = 3'd3,
    ST_FN_SEND  = 3'd4,
    ST_TK_RUN   = 3'd5,
    ST_TK_SEND  = 3'd6
  } cbr_state_e;

  // Controlled time may advance only when idle or while a task body runs.
  function automatic logic clock_runs(input cbr_state_e s);
    return (s == ST_IDLE) || (s == ST_TK_RUN);
  endfunction

  function automatic logic is_send(input cbr_state_e s);
    return (s == ST_IMP_SEND) || (s == ST_FN_SEND) || (s == ST_TK_SEND);
  endfunction

endpackage

// File: rtl/cbr_enable.sv
module cbr_enable
  import cbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  cbr_state_e state_nx,
  output logic       cclk_en
);

  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b1;
    else     en_q <= clock_runs(state_nx);
  end

  assign cclk_en = en_q;

endmodule

// File: rtl/cbr_ctrl.sv
module cbr_ctrl
  import cbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       imp_req_valid,
  input  logic       in_valid,
  input  logic       in_is_task,
  input  logic       out_ready,
  input  logic       exp_fin,
  input  logic       cclk_en,
  output cbr_state_e state_nx,
  output logic       imp_req_ready,
  output logic       in_ready,
  output logic       out_valid,
  output logic       imp_take,
  output logic       exp_take,
  output logic       reply_take,
  output logic       fin_take,
  output logic       exp_go,
  output logic       imp_done
);

  cbr_state_e state_q;
  logic idle, in_fire, out_fire, waiting_reply, running;
  logic exp_go_q, imp_done_q;

  assign idle          = (state_q == ST_IDLE);
  assign waiting_reply = (state_q == ST_IMP_WAIT);
  assign running       = (state_q == ST_FN_RUN) || (state_q == ST_TK_RUN);

  assign imp_req_ready = idle;
  assign in_ready      = (idle && !imp_req_valid) || waiting_reply;
  assign out_valid     = is_send(state_q);

  assign in_fire    = in_valid && in_ready;
  assign out_fire   = out_valid && out_ready;
  assign imp_take   = idle && imp_req_valid;
  assign exp_take   = idle && in_fire;
  assign reply_take = waiting_reply && in_fire;
  assign fin_take   = running && exp_fin;

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (imp_take)      state_nx = ST_IMP_SEND;
        else if (exp_take) state_nx = in_is_task ? ST_TK_RUN : ST_FN_RUN;
      end
      ST_IMP_SEND: if (out_fire)   state_nx = ST_IMP_WAIT;
      ST_IMP_WAIT: if (reply_take) state_nx = ST_IDLE;
      ST_FN_RUN:   if (fin_take)   state_nx = ST_FN_SEND;
      ST_TK_RUN:   if (fin_take)   state_nx = ST_TK_SEND;
      ST_FN_SEND,
      ST_TK_SEND:  if (out_fire)   state_nx = ST_IDLE;
      default:                     state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      exp_go_q   <= 1'b0;
      imp_done_q <= 1'b0;
    end else begin
      state_q    <= state_nx;
      exp_go_q   <= exp_take;
      imp_done_q <= reply_take;
    end
  end

  assign exp_go   = exp_go_q;
  assign imp_done = imp_done_q;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> cclk_en && !out_valid && imp_req_ready && !exp_go && !imp_done);

  // R2
  imp_stop_chk: assert property (@(posedge clk) disable iff (rst)
    imp_take |=> !cclk_en && out_valid);

  // R3
  send_paused_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !cclk_en);

  // R3
  ports_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  // R4
  reply_restart_chk: assert property (@(posedge clk) disable iff (rst)
    reply_take |=> cclk_en && imp_done);

  // R5
  fn_stop_chk: assert property (@(posedge clk) disable iff (rst)
    exp_take && !in_is_task |=> !cclk_en && exp_go);

  // R7
  task_runs_chk: assert property (@(posedge clk) disable iff (rst)
    exp_take && in_is_task |=> cclk_en && exp_go);

  // R6
  fin_send_chk: assert property (@(posedge clk) disable iff (rst)
    fin_take |=> out_valid && !cclk_en);

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !imp_req_ready);

  // R10
  fin_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    exp_fin && idle && !imp_req_valid && !in_valid |=> !out_valid && cclk_en);

endmodule

// File: rtl/cbr_datapath.sv
module cbr_datapath #(
  parameter int ID_W  = 6,
  parameter int FLD_W = 16,
  parameter int NFLD  = 4,
  localparam int FW    = NFLD * FLD_W,
  localparam int MSG_W = ID_W + FW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             imp_take,
  input  logic             exp_take,
  input  logic             reply_take,
  input  logic             fin_take,
  input  logic [ID_W-1:0]  imp_id,
  input  logic [FW-1:0]    imp_args,
  input  logic [MSG_W-1:0] in_msg,
  input  logic [FW-1:0]    exp_res,
  output logic             in_is_task,
  output logic [MSG_W-1:0] out_msg,
  output logic [FW-1:0]    imp_res,
  output logic [ID_W-1:0]  exp_id,
  output logic [FW-1:0]    exp_args
);

  function automatic logic [MSG_W-1:0] pack_msg(input logic [ID_W-1:0] id,
                                                input logic [FW-1:0]   f);
    logic [MSG_W-1:0] m;
    m = '0;
    m[ID_W-1:0] = id;
    for (int k = 0; k < NFLD; k++)
      m[ID_W + k*FLD_W +: FLD_W] = f[k*FLD_W +: FLD_W];
    return m;
  endfunction

  function automatic logic [FW-1:0] unpack_fields(input logic [MSG_W-1:0] m);
    logic [FW-1:0] f;
    for (int k = 0; k < NFLD; k++)
      f[k*FLD_W +: FLD_W] = m[ID_W + k*FLD_W +: FLD_W];
    return f;
  endfunction

  logic [MSG_W-1:0] out_q;
  logic [FW-1:0]    res_q, args_q;
  logic [ID_W-1:0]  id_q;

  assign in_is_task = in_msg[ID_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      res_q  <= '0;
      args_q <= '0;
      id_q   <= '0;
    end else begin
      if (imp_take)      out_q <= pack_msg(imp_id, imp_args);
      else if (fin_take) out_q <= pack_msg(id_q, exp_res);
      if (reply_take) res_q <= unpack_fields(in_msg);
      if (exp_take) begin
        id_q   <= in_msg[ID_W-1:0];
        args_q <= unpack_fields(in_msg);
      end
    end
  end

  assign out_msg  = out_q;
  assign imp_res  = res_q;
  assign exp_id   = id_q;
  assign exp_args = args_q;

  // R5
  args_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !exp_take |=> $stable(exp_args) && $stable(exp_id));

  // R4
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reply_take |=> $stable(imp_res));

endmodule

// File: rtl/fcall_bridge.sv
module fcall_bridge
  import cbr_pkg::*;
#(
  parameter int ID_W  = 6,
  parameter int FLD_W = 16,
  parameter int NFLD  = 4,
  localparam int FW    = NFLD * FLD_W,
  localparam int MSG_W = ID_W + FW
) (
  input  logic             clk,
  input  logic             rst,
  output logic             cclk_en,
  input  logic             imp_req_valid,
  output logic             imp_req_ready,
  input  logic [ID_W-1:0]  imp_id,
  input  logic [FW-1:0]    imp_args,
  output logic             imp_done,
  output logic [FW-1:0]    imp_res,
  output logic             exp_go,
  output logic [ID_W-1:0]  exp_id,
  output logic [FW-1:0]    exp_args,
  input  logic             exp_fin,
  input  logic [FW-1:0]    exp_res,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [MSG_W-1:0] out_msg,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [MSG_W-1:0] in_msg
);

  cbr_state_e state_nx;
  logic in_is_task, imp_take, exp_take, reply_take, fin_take;

  cbr_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .imp_req_valid (imp_req_valid),
    .in_valid      (in_valid),
    .in_is_task    (in_is_task),
    .out_ready     (out_ready),
    .exp_fin       (exp_fin),
    .cclk_en       (cclk_en),
    .state_nx      (state_nx),
    .imp_req_ready (imp_req_ready),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .imp_take      (imp_take),
    .exp_take      (exp_take),
    .reply_take    (reply_take),
    .fin_take      (fin_take),
    .exp_go        (exp_go),
    .imp_done      (imp_done)
  );

  cbr_enable u_enable (
    .clk      (clk),
    .rst      (rst),
    .state_nx (state_nx),
    .cclk_en  (cclk_en)
  );

  cbr_datapath #(.ID_W(ID_W), .FLD_W(FLD_W), .NFLD(NFLD)) u_data (
    .clk        (clk),
    .rst        (rst),
    .imp_take   (imp_take),
    .exp_take   (exp_take),
    .reply_take (reply_take),
    .fin_take   (fin_take),
    .imp_id     (imp_id),
    .imp_args   (imp_args),
    .in_msg     (in_msg),
    .exp_res    (exp_res),
    .in_is_task (in_is_task),
    .out_msg    (out_msg),
    .imp_res    (imp_res),
    .exp_id     (exp_id),
    .exp_args   (exp_args)
  );

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_msg));

endmodule

// File: tb/fcall_bridge_tb_top.sv
module fcall_bridge_tb_top;

  localparam int ID_W  = 4;
  localparam int FLD_W = 8;
  localparam int NFLD  = 3;
  localparam int FW    = NFLD * FLD_W;
  localparam int MSG_W = ID_W + FW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic             cclk_en, imp_req_valid, imp_req_ready, imp_done, exp_go, exp_fin;
  logic             out_valid, out_ready, in_valid, in_ready;
  logic [ID_W-1:0]  imp_id, exp_id;
  logic [FW-1:0]    imp_args, imp_res, exp_args, exp_res;
  logic [MSG_W-1:0] out_msg, in_msg;

  fcall_bridge #(.ID_W(ID_W), .FLD_W(FLD_W), .NFLD(NFLD)) dut_i (
    .clk(clk), .rst(rst), .cclk_en(cclk_en),
    .imp_req_valid(imp_req_valid), .imp_req_ready(imp_req_ready),
    .imp_id(imp_id), .imp_args(imp_args), .imp_done(imp_done), .imp_res(imp_res),
    .exp_go(exp_go), .exp_id(exp_id), .exp_args(exp_args),
    .exp_fin(exp_fin), .exp_res(exp_res),
    .out_valid(out_valid), .out_ready(out_ready), .out_msg(out_msg),
    .in_valid(in_valid), .in_ready(in_ready), .in_msg(in_msg)
  );

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  function automatic logic [MSG_W-1:0] mk_msg(input logic [ID_W-1:0] id,
                                              input logic [FW-1:0] f);
    logic [MSG_W-1:0] m = '0;
    for (int k = NFLD - 1; k >= 0; k--)
      m = (m << FLD_W) | MSG_W'((f >> (k * FLD_W)) & {FLD_W{1'b1}});
    return (m << ID_W) | MSG_W'(id);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
  endtask

  task automatic run_import(input logic [ID_W-1:0] id, input logic [FW-1:0] args,
                            input logic [FW-1:0] res, input int send_wait,
                            input int reply_wait, input bit collide, input bit noise);
    logic [MSG_W-1:0] held;
    imp_req_valid = 1'b1; imp_id = id; imp_args = args;
    if (collide) begin
      in_valid = 1'b1; in_msg = mk_msg(4'hB, ~args);
    end
    #0.5;
    check("R9 import ready when idle", imp_req_ready, 1'b1);
    if (collide) check("R9 collision in_ready", in_ready, 1'b0);
    tick;
    imp_req_valid = 1'b0; in_valid = 1'b0;
    check("R2 clock stopped", cclk_en, 1'b0);
    check("R2 out_valid", out_valid, 1'b1);
    check("R2 out_msg", out_msg, mk_msg(id, args));
    held = out_msg;
    out_ready = 1'b0;
    for (int i = 0; i < send_wait; i++) begin
      tick;
      check("R8 held valid", out_valid, 1'b1);
      check("R8 held msg", out_msg, held);
      check("R3 paused in send", cclk_en, 1'b0);
      check("R3 in_ready low in send", in_ready, 1'b0);
    end
    out_ready = 1'b1;
    tick;
    out_ready = 1'b0;
    check("R3 sent", out_valid, 1'b0);
    check("R3 paused in wait", cclk_en, 1'b0);
    check("R3 in_ready in wait", in_ready, 1'b1);
    for (int i = 0; i < reply_wait; i++) begin
      exp_fin = noise;
      tick;
      exp_fin = 1'b0;
      check("R3 paused in wait", cclk_en, 1'b0);
      check("R10 no message from stray fin", out_valid, 1'b0);
    end
    in_valid = 1'b1;
    in_msg = mk_msg(ID_W'($urandom), res);
    tick;
    in_valid = 1'b0;
    check("R4 imp_done", imp_done, 1'b1);
    check("R4 imp_res", imp_res, res);
    check("R4 clock restarted", cclk_en, 1'b1);
    tick;
    check("R4 imp_done pulse", imp_done, 1'b0);
  endtask

  task automatic run_export(input bit is_task, input logic [ID_W-2:0] idlo,
                            input logic [FW-1:0] args, input logic [FW-1:0] res,
                            input int run_wait, input int send_wait);
    logic [ID_W-1:0] id;
    logic [MSG_W-1:0] held;
    string rq;
    rq = is_task ? "R7" : "R5";
    id = {is_task, idlo};
    in_valid = 1'b1; in_msg = mk_msg(id, args);
    #0.5;
    check({rq, " in_ready idle"}, in_ready, 1'b1);
    tick;
    in_valid = 1'b0;
    check({rq, " exp_go"}, exp_go, 1'b1);
    check({rq, " exp_id"}, exp_id, id);
    check({rq, " exp_args"}, exp_args, args);
    check({rq, " clock at start"}, cclk_en, is_task);
    for (int i = 0; i < run_wait; i++) begin
      imp_req_valid = 1'b1;
      #0.5;
      check("R9 busy blocks import", imp_req_ready, 1'b0);
      imp_req_valid = 1'b0;
      tick;
      check({rq, " exp_go pulse"}, exp_go, 1'b0);
      check({rq, " clock while running"}, cclk_en, is_task);
      check({rq, " args held"}, exp_args, args);
    end
    exp_fin = 1'b1; exp_res = res;
    tick;
    exp_fin = 1'b0;
    check("R6 result valid", out_valid, 1'b1);
    check("R6 result msg", out_msg, mk_msg(id, res));
    check(is_task ? "R7 paused in send" : "R6 paused in send", cclk_en, 1'b0);
    held = out_msg;
    out_ready = 1'b0;
    for (int i = 0; i < send_wait; i++) begin
      tick;
      check("R8 held msg", out_msg, held);
      check(is_task ? "R7 paused in send" : "R6 paused in send", cclk_en, 1'b0);
    end
    out_ready = 1'b1;
    tick;
    out_ready = 1'b0;
    check("R6 sent", out_valid, 1'b0);
    check(is_task ? "R7 restarted" : "R6 restarted", cclk_en, 1'b1);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20051006));
    imp_req_valid = 1'b0; imp_id = '0; imp_args = '0;
    exp_fin = 1'b0; exp_res = '0;
    out_ready = 1'b0; in_valid = 1'b0; in_msg = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 cclk_en", cclk_en, 1'b1);
    check("R1 out_valid", out_valid, 1'b0);
    check("R1 imp_req_ready", imp_req_ready, 1'b1);
    check("R1 in_ready", in_ready, 1'b1);
    check("R1 imp_done", imp_done, 1'b0);
    check("R1 exp_go", exp_go, 1'b0);

    // R10 stray finish while idle
    exp_fin = 1'b1;
    tick;
    exp_fin = 1'b0;
    check("R10 no message", out_valid, 1'b0);
    check("R10 clock unchanged", cclk_en, 1'b1);
    check("R10 no start", exp_go, 1'b0);

    // Directed corners
    run_import(4'h0, '0, '1, 0, 0, 1'b0, 1'b0);
    run_import(4'hF, '1, '0, 3, 2, 1'b0, 1'b1);
    run_import(4'h5, 24'h123456, 24'hA5C3E1, 1, 1, 1'b1, 1'b0);   // R9 collision
    run_export(1'b0, 3'h0, '1, 24'h00FF00, 0, 0);
    run_export(1'b1, 3'h7, '0, 24'hFF00FF, 0, 0);
    run_export(1'b1, 3'h2, 24'h010203, 24'h0A0B0C, 4, 3);

    // Constrained random mix
    for (int n = 0; n < 60; n++) begin
      case ($urandom % 3)
        0: run_import(ID_W'($urandom), FW'($urandom), FW'($urandom),
                      $urandom % 5, $urandom % 5, 1'($urandom), 1'($urandom));
        1: run_export(1'b0, 3'($urandom), FW'($urandom), FW'($urandom),
                      $urandom % 5, $urandom % 5);
        default: run_export(1'b1, 3'($urandom), FW'($urandom), FW'($urandom),
                            $urandom % 5, $urandom % 5);
      endcase
      repeat ($urandom % 3) begin
        tick;
        check("R1 idle enable", cclk_en, 1'b1);
      end
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule